// File: doc/BRIEF.md
# Two-Port Clock-Sampled Static Memory Model

This block is a 4096-word by 8-bit storage array with two equal, unrelated access ports, called left and right. Each port carries its own 12-bit address, an 8-bit write-data input, an 8-bit read-data output with a separate drive flag standing in for a tristate pin, and three active-low strobes: select, read-not-write and output drive. The port pins are sampled on one system clock, so an access that spans several pin states on a real memory spans several clock samples here.

A write is a window, not a pulse. It opens in the first sample where select and read-not-write are both low, and it is stored when that window closes, using the address and data of the final sample inside it. Moving the address while the window is open is a protocol fault. The port's fault output pulses and that write is discarded. The ports are not arbitrated. A contention output marks any sample where both ports are selected on one address and at least one of them is writing. If both ports store to one word on the same edge, the left value is kept.

Top module: `dpram_ctrl`

## Requirements
- R1: After reset, both read-data outputs are 0, both drive flags are 0, both fault outputs are 0 and the contention output is 0.
- R2: A sample with select high gives drive flag 0 and read data 0 one cycle later, and stores nothing, even with read-not-write low.
- R3: A sample with select low, read-not-write high and output drive low gives drive flag 1 one cycle later, with read data equal to the stored word at the sampled address.
- R4: A sample with output drive high gives drive flag 0 one cycle later, whatever the other strobes are.
- R5: A write window stores its data on the clock edge of the first sample after the window closes, using the address and data of the last sample in the window. A read sampled in that same cycle returns the old word. A read sampled one cycle later returns the new word.
- R6: A sample with read-not-write low gives drive flag 0 one cycle later, so the output stays undriven for the whole write window, including a window where select falls together with or after read-not-write.
- R7: A word stored through one port is returned by the other port at the same address once the store has taken place.
- R8: If the address of a sample inside a write window differs from the address of the previous sample of the same window, that port's fault output is 1 for exactly one cycle, one cycle after that sample, and the window stores nothing.
- R9: The contention output is 1 one cycle after a sample in which both selects are low, both addresses are equal and at least one read-not-write is low. Otherwise it is 0.
- R10: When both ports store to the same address on the same edge, the word afterwards holds the left port's data.
- R11: A write on one port and a read on the other port at a different address in the same samples both complete correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all pins sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| l_ce_n | input | 1 | Left select, active low |
| l_rw_n | input | 1 | Left read-not-write, low writes |
| l_oe_n | input | 1 | Left output drive, active low |
| l_addr | input | 12 | Left word address |
| l_wdata | input | 8 | Left write data |
| l_rdata | output | 8 | Left read data, 0 when not driven |
| l_rdata_oe | output | 1 | Left drive flag; 0 stands for high impedance |
| l_err | output | 1 | Left fault pulse for an address move inside a write window |
| r_ce_n | input | 1 | Right select, active low |
| r_rw_n | input | 1 | Right read-not-write, low writes |
| r_oe_n | input | 1 | Right output drive, active low |
| r_addr | input | 12 | Right word address |
| r_wdata | input | 8 | Right write data |
| r_rdata | output | 8 | Right read data, 0 when not driven |
| r_rdata_oe | output | 1 | Right drive flag; 0 stands for high impedance |
| r_err | output | 1 | Right fault pulse for an address move inside a write window |
| coll | output | 1 | Same-address contention flag |

## Verification
Read data, drive flags, fault pulses and the contention flag all come from one register stage, so each is due right after the clock edge that samples its stimulus. The bench drives pins just after an edge and reads outputs one time unit after the next edge. A store lands on the edge that samples the first pin state after its window closes. The bench therefore expects the old word from a read sampled on that edge and the new word from a read one edge later, and it updates its reference array only at that point. The random phase pairs a write window on one port with a read on the other in the same sample. It predicts the old word and the contention value from its reference array before the store is applied.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

    // Array geometry; every width below derives from these two.
    localparam int unsigned ADDR_W = 12;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned DEPTH  = 1 << ADDR_W;
    localparam int unsigned NPORT  = 2;
    localparam int unsigned PORT_L = 0;
    localparam int unsigned PORT_R = 1;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;

    // Pin state of one port as sampled on a clock edge.
    typedef struct packed {
        logic  ce_n;
        logic  rw_n;
        logic  oe_n;
        addr_t addr;
        data_t data;
    } port_in_t;

    // A store request toward the array.
    typedef struct packed {
        logic  en;
        addr_t addr;
        data_t data;
    } wr_req_t;

    // Select and write strobe are both active: a write window is open.
    function automatic logic win_open(input port_in_t p);
        return !p.ce_n && !p.rw_n;
    endfunction

    // The port asks for the addressed word on its output.
    function automatic logic drive_req(input port_in_t p);
        return !p.ce_n && p.rw_n && !p.oe_n;
    endfunction

    // Either port is writing while both sit on one address.
    function automatic logic clash(input port_in_t a, input port_in_t b);
        return !a.ce_n && !b.ce_n && (a.addr == b.addr) && (!a.rw_n || !b.rw_n);
    endfunction

endpackage

// File: rtl/dpram_port_ctrl.sv
module dpram_port_ctrl
    import dpram_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  port_in_t pin,
    output wr_req_t  wr,
    output logic     rd_sel,
    output logic     err
);

    logic  open_q;
    logic  spoil_q;
    addr_t addr_q;
    data_t data_q;
    logic  open_now;
    logic  moved;

    assign open_now = win_open(pin);
    // Address moved between two consecutive samples of one window.
    assign moved    = open_now && open_q && (pin.addr != addr_q);

    // Window closed this sample: store what the last open sample carried.
    assign wr.en   = open_q && !open_now && !spoil_q;
    assign wr.addr = addr_q;
    assign wr.data = data_q;
    assign rd_sel  = drive_req(pin);

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q  <= 1'b0;
            spoil_q <= 1'b0;
            addr_q  <= '0;
            data_q  <= '0;
            err     <= 1'b0;
        end else begin
            open_q  <= open_now;
            spoil_q <= open_now && ((open_q && spoil_q) || moved);
            addr_q  <= pin.addr;
            data_q  <= pin.data;
            err     <= moved;
        end
    end

endmodule

// File: rtl/dpram_store.sv
module dpram_store
    import dpram_pkg::*;
#(
    parameter int unsigned WORDS = dpram_pkg::DEPTH
) (
    input  logic                  clk,
    input  logic                  rst,
    input  wr_req_t [NPORT-1:0]   wr,
    input  addr_t   [NPORT-1:0]   raddr,
    input  logic    [NPORT-1:0]   rsel,
    output data_t   [NPORT-1:0]   rdata,
    output logic    [NPORT-1:0]   rvalid
);

    data_t mem [WORDS];

    // Highest index first, so the left port (index 0) lands last and wins.
    always_ff @(posedge clk) begin
        for (int p = NPORT - 1; p >= 0; p--) begin
            if (wr[p].en) begin
                mem[wr[p].addr] <= wr[p].data;
            end
        end
    end

    // Registered read: old contents when a store shares the edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            rdata  <= '0;
            rvalid <= '0;
        end else begin
            for (int p = 0; p < NPORT; p++) begin
                rvalid[p] <= rsel[p];
                rdata[p]  <= rsel[p] ? mem[raddr[p]] : '0;
            end
        end
    end

endmodule

// File: rtl/dpram_clash_det.sv
module dpram_clash_det
    import dpram_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  port_in_t pa,
    input  port_in_t pb,
    output logic     coll
);

    always_ff @(posedge clk) begin
        if (rst) begin
            coll <= 1'b0;
        end else begin
            coll <= clash(pa, pb);
        end
    end

endmodule

// File: rtl/dpram_ctrl.sv
module dpram_ctrl
    import dpram_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              l_ce_n,
    input  logic              l_rw_n,
    input  logic              l_oe_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    output logic              l_rdata_oe,
    output logic              l_err,
    input  logic              r_ce_n,
    input  logic              r_rw_n,
    input  logic              r_oe_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata,
    output logic              r_rdata_oe,
    output logic              r_err,
    output logic              coll
);

    port_in_t [NPORT-1:0] pins;
    wr_req_t  [NPORT-1:0] wreq;
    addr_t    [NPORT-1:0] raddr;
    logic     [NPORT-1:0] rsel;
    logic     [NPORT-1:0] perr;
    data_t    [NPORT-1:0] rdata;
    logic     [NPORT-1:0] rvalid;

    assign pins[PORT_L] = '{ce_n: l_ce_n, rw_n: l_rw_n, oe_n: l_oe_n,
                            addr: l_addr, data: l_wdata};
    assign pins[PORT_R] = '{ce_n: r_ce_n, rw_n: r_rw_n, oe_n: r_oe_n,
                            addr: r_addr, data: r_wdata};

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        dpram_port_ctrl u_ctrl (
            .clk    (clk),
            .rst    (rst),
            .pin    (pins[p]),
            .wr     (wreq[p]),
            .rd_sel (rsel[p]),
            .err    (perr[p])
        );
        assign raddr[p] = pins[p].addr;
    end

    dpram_store #(.WORDS(DEPTH)) u_store (
        .clk    (clk),
        .rst    (rst),
        .wr     (wreq),
        .raddr  (raddr),
        .rsel   (rsel),
        .rdata  (rdata),
        .rvalid (rvalid)
    );

    dpram_clash_det u_clash (
        .clk  (clk),
        .rst  (rst),
        .pa   (pins[PORT_L]),
        .pb   (pins[PORT_R]),
        .coll (coll)
    );

    assign l_rdata    = rdata[PORT_L];
    assign l_rdata_oe = rvalid[PORT_L];
    assign l_err      = perr[PORT_L];
    assign r_rdata    = rdata[PORT_R];
    assign r_rdata_oe = rvalid[PORT_R];
    assign r_err      = perr[PORT_R];

endmodule

// File: rtl/dpram_ctrl_chk.sv
module dpram_ctrl_chk
    import dpram_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              l_ce_n,
    input logic              l_rw_n,
    input logic              l_oe_n,
    input logic [ADDR_W-1:0] l_addr,
    input logic              l_rdata_oe,
    input logic              l_err,
    input logic              r_ce_n,
    input logic              r_rw_n,
    input logic              r_oe_n,
    input logic [ADDR_W-1:0] r_addr,
    input logic              r_rdata_oe,
    input logic              r_err,
    input logic              coll
);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!l_rdata_oe && !r_rdata_oe && !l_err && !r_err && !coll));

    assert_deselect_hiz_R2: assert property (@(posedge clk) disable iff (rst)
        (l_ce_n |=> !l_rdata_oe) and (r_ce_n |=> !r_rdata_oe));

    assert_read_drives_R3: assert property (@(posedge clk) disable iff (rst)
        (!l_ce_n && l_rw_n && !l_oe_n) |=> l_rdata_oe);

    assert_oe_off_hiz_R4: assert property (@(posedge clk) disable iff (rst)
        (l_oe_n |=> !l_rdata_oe) and (r_oe_n |=> !r_rdata_oe));

    assert_write_hiz_R6: assert property (@(posedge clk) disable iff (rst)
        (!l_rw_n |=> !l_rdata_oe) and (!r_rw_n |=> !r_rdata_oe));

    assert_fault_in_window_R8: assert property (@(posedge clk) disable iff (rst)
        l_err |-> ($past(!l_ce_n && !l_rw_n) && $past(l_addr) != $past(l_addr, 2)));

    assert_fault_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        r_err |=> !r_err || $past(!r_ce_n && !r_rw_n));

    assert_coll_cause_R9: assert property (@(posedge clk) disable iff (rst)
        coll |-> $past(!l_ce_n && !r_ce_n && (l_addr == r_addr) && (!l_rw_n || !r_rw_n)));

endmodule

bind dpram_ctrl dpram_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .l_ce_n     (l_ce_n),
    .l_rw_n     (l_rw_n),
    .l_oe_n     (l_oe_n),
    .l_addr     (l_addr),
    .l_rdata_oe (l_rdata_oe),
    .l_err      (l_err),
    .r_ce_n     (r_ce_n),
    .r_rw_n     (r_rw_n),
    .r_oe_n     (r_oe_n),
    .r_addr     (r_addr),
    .r_rdata_oe (r_rdata_oe),
    .r_err      (r_err),
    .coll       (coll)
);

// File: tb/test_dpram_ctrl.sv
module test_dpram_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 12;
    localparam int DW = 8;
    localparam int RAND_WORDS = 64;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          l_ce_n = 1'b1, l_rw_n = 1'b1, l_oe_n = 1'b1;
    logic [AW-1:0] l_addr = '0;
    logic [DW-1:0] l_wdata = '0;
    logic          r_ce_n = 1'b1, r_rw_n = 1'b1, r_oe_n = 1'b1;
    logic [AW-1:0] r_addr = '0;
    logic [DW-1:0] r_wdata = '0;
    logic [DW-1:0] l_rdata, r_rdata;
    logic          l_rdata_oe, r_rdata_oe, l_err, r_err, coll;

    int n_chk = 0;
    int n_fail = 0;
    logic [DW-1:0] model [RAND_WORDS];

    always #(CLK_PERIOD / 2) clk = ~clk;

    dpram_ctrl i_dpram_ctrl (
        .clk(clk), .rst(rst),
        .l_ce_n(l_ce_n), .l_rw_n(l_rw_n), .l_oe_n(l_oe_n), .l_addr(l_addr),
        .l_wdata(l_wdata), .l_rdata(l_rdata), .l_rdata_oe(l_rdata_oe), .l_err(l_err),
        .r_ce_n(r_ce_n), .r_rw_n(r_rw_n), .r_oe_n(r_oe_n), .r_addr(r_addr),
        .r_wdata(r_wdata), .r_rdata(r_rdata), .r_rdata_oe(r_rdata_oe), .r_err(r_err),
        .coll(coll)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // One clock edge, then settle; pins set after this are sampled next edge.
    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic idle_all();
        l_ce_n = 1'b1; l_rw_n = 1'b1; l_oe_n = 1'b1;
        r_ce_n = 1'b1; r_rw_n = 1'b1; r_oe_n = 1'b1;
    endtask

    task automatic write_l(input logic [AW-1:0] a, input logic [DW-1:0] d);
        l_ce_n = 1'b0; l_rw_n = 1'b0; l_addr = a; l_wdata = d;
        cyc();
        l_ce_n = 1'b1; l_rw_n = 1'b1;
        cyc();
    endtask

    task automatic write_r(input logic [AW-1:0] a, input logic [DW-1:0] d);
        r_ce_n = 1'b0; r_rw_n = 1'b0; r_addr = a; r_wdata = d;
        cyc();
        r_ce_n = 1'b1; r_rw_n = 1'b1;
        cyc();
    endtask

    task automatic read_l(input logic [AW-1:0] a, output logic [DW-1:0] d, output logic oe);
        l_ce_n = 1'b0; l_rw_n = 1'b1; l_oe_n = 1'b0; l_addr = a;
        cyc();
        d = l_rdata; oe = l_rdata_oe;
        l_ce_n = 1'b1; l_oe_n = 1'b1;
    endtask

    task automatic read_r(input logic [AW-1:0] a, output logic [DW-1:0] d, output logic oe);
        r_ce_n = 1'b0; r_rw_n = 1'b1; r_oe_n = 1'b0; r_addr = a;
        cyc();
        d = r_rdata; oe = r_rdata_oe;
        r_ce_n = 1'b1; r_oe_n = 1'b1;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : stim
        logic [DW-1:0] d;
        logic          oe;
        void'($urandom(32'd20240611));

        repeat (3) cyc();
        // R1: reset values
        chk("R1 l_rdata_oe", int'(l_rdata_oe), 0);
        chk("R1 r_rdata_oe", int'(r_rdata_oe), 0);
        chk("R1 l_rdata", int'(l_rdata), 0);
        chk("R1 errs", int'({l_err, r_err}), 0);
        chk("R1 coll", int'(coll), 0);
        rst = 1'b0;
        cyc();

        // R7 / R3: left stores, right returns it; and the other direction
        write_l(12'd5, 8'hA5);
        read_r(12'd5, d, oe);
        chk("R7 right sees left store", int'(d), 'hA5);
        chk("R3 right drive flag", int'(oe), 1);
        write_r(12'd6, 8'h3C);
        read_l(12'd6, d, oe);
        chk("R7 left sees right store", int'(d), 'h3C);
        chk("R3 left drive flag", int'(oe), 1);

        // R4: output drive high on a read
        l_ce_n = 1'b0; l_rw_n = 1'b1; l_oe_n = 1'b1; l_addr = 12'd5;
        cyc();
        chk("R4 oe_n high gives no drive", int'(l_rdata_oe), 0);
        idle_all();

        // R2: deselected write attempt stores nothing, no drive
        l_ce_n = 1'b1; l_rw_n = 1'b0; l_oe_n = 1'b0; l_addr = 12'd5; l_wdata = 8'hFF;
        cyc();
        chk("R2 deselected drive flag", int'(l_rdata_oe), 0);
        chk("R2 deselected data", int'(l_rdata), 0);
        idle_all();
        cyc();
        read_r(12'd5, d, oe);
        chk("R2 deselected write ignored", int'(d), 'hA5);

        // R6: select falls with write strobe while oe_n low
        l_ce_n = 1'b0; l_rw_n = 1'b0; l_oe_n = 1'b0; l_addr = 12'd8; l_wdata = 8'h5E;
        cyc();
        chk("R6 no drive in write window", int'(l_rdata_oe), 0);
        cyc();
        chk("R6 no drive in write window 2nd", int'(l_rdata_oe), 0);
        idle_all();
        cyc();

        // R5: store timing, read-old on the commit edge then new
        write_l(12'd7, 8'h22);
        l_ce_n = 1'b0; l_rw_n = 1'b0; l_addr = 12'd7; l_wdata = 8'h11;
        cyc();
        l_ce_n = 1'b1; l_rw_n = 1'b1;
        r_ce_n = 1'b0; r_rw_n = 1'b1; r_oe_n = 1'b0; r_addr = 12'd7;
        cyc();
        chk("R5 old word on commit edge", int'(r_rdata), 'h22);
        cyc();
        chk("R5 new word one edge later", int'(r_rdata), 'h11);
        idle_all();

        // R8: address move inside a window
        write_l(12'd9, 8'h33);
        write_l(12'd10, 8'h44);
        l_ce_n = 1'b0; l_rw_n = 1'b0; l_addr = 12'd9; l_wdata = 8'h77;
        cyc();
        chk("R8 no fault before move", int'(l_err), 0);
        l_addr = 12'd10;
        cyc();
        chk("R8 fault on move", int'(l_err), 1);
        l_ce_n = 1'b1; l_rw_n = 1'b1;
        cyc();
        chk("R8 fault is one cycle", int'(l_err), 0);
        cyc();
        read_r(12'd9, d, oe);
        chk("R8 first address untouched", int'(d), 'h33);
        read_r(12'd10, d, oe);
        chk("R8 second address untouched", int'(d), 'h44);

        // R9: contention flag
        l_ce_n = 1'b0; l_rw_n = 1'b0; l_addr = 12'd40; l_wdata = 8'h01;
        r_ce_n = 1'b0; r_rw_n = 1'b1; r_oe_n = 1'b0; r_addr = 12'd40;
        cyc();
        chk("R9 write vs read same address", int'(coll), 1);
        idle_all();
        cyc();
        chk("R9 clears when idle", int'(coll), 0);
        l_ce_n = 1'b0; l_oe_n = 1'b0; l_addr = 12'd40;
        r_ce_n = 1'b0; r_oe_n = 1'b0; r_addr = 12'd40;
        cyc();
        chk("R9 two reads no contention", int'(coll), 0);
        chk("R7 both read stored word", int'({l_rdata, r_rdata}), 'h0101);
        idle_all();

        // R10: same-edge stores to one address, left wins
        l_ce_n = 1'b0; l_rw_n = 1'b0; l_addr = 12'd12; l_wdata = 8'h5A;
        r_ce_n = 1'b0; r_rw_n = 1'b0; r_addr = 12'd12; r_wdata = 8'hA5;
        cyc();
        chk("R9 two writers", int'(coll), 1);
        idle_all();
        cyc();
        read_r(12'd12, d, oe);
        chk("R10 left data kept", int'(d), 'h5A);

        // R11: concurrent write and read, different addresses
        write_r(12'd30, 8'h99);
        l_ce_n = 1'b0; l_rw_n = 1'b0; l_addr = 12'd20; l_wdata = 8'h66;
        r_ce_n = 1'b0; r_rw_n = 1'b1; r_oe_n = 1'b0; r_addr = 12'd30;
        cyc();
        chk("R11 concurrent read data", int'(r_rdata), 'h99);
        chk("R11 writer not driving", int'(l_rdata_oe), 0);
        chk("R9 different addresses", int'(coll), 0);
        idle_all();
        cyc();
        read_r(12'd20, d, oe);
        chk("R11 concurrent store landed", int'(d), 'h66);

        // Random phase: fill reference, then paired write/read samples
        for (int i = 0; i < RAND_WORDS; i++) begin
            model[i] = 8'($urandom);
            write_l(AW'(i), model[i]);
        end
        for (int it = 0; it < 400; it++) begin
            int  wa = int'($urandom % RAND_WORDS);
            int  ra = int'($urandom % RAND_WORDS);
            logic [DW-1:0] wd = 8'($urandom);
            bit  left_writes = 1'($urandom);
            if (left_writes) begin
                l_ce_n = 1'b0; l_rw_n = 1'b0; l_addr = AW'(wa); l_wdata = wd;
                r_ce_n = 1'b0; r_rw_n = 1'b1; r_oe_n = 1'b0; r_addr = AW'(ra);
            end else begin
                r_ce_n = 1'b0; r_rw_n = 1'b0; r_addr = AW'(wa); r_wdata = wd;
                l_ce_n = 1'b0; l_rw_n = 1'b1; l_oe_n = 1'b0; l_addr = AW'(ra);
            end
            cyc();
            chk("R11 random read old word", int'(left_writes ? r_rdata : l_rdata), int'(model[ra]));
            chk("R9 random contention", int'(coll), int'(wa == ra));
            idle_all();
            cyc();
            model[wa] = wd;
            if (it % 8 == 0) begin
                if (left_writes) read_r(AW'(wa), d, oe);
                else             read_l(AW'(wa), d, oe);
                chk("R7 random cross-port read", int'(d), int'(model[wa]));
                chk("R3 random drive flag", int'(oe), 1);
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule